// File: doc/BRIEF.md
# Versioned Compare-and-Swap Unit

This block is a small shared store of pointer slots that several requesters update through atomic compare-and-swap. Each slot holds a pointer word and an update stamp. A requester names a slot and gives an expected pointer, an expected stamp and a replacement pointer. The write happens only when both the pointer and the stamp match what the slot holds. Every successful write also advances the stamp. This means a pointer value that was freed and then handed out again cannot let a stale request succeed.

A test-and-set operation uses the same path. It treats the pointer word of a slot as a flag and ignores the expected fields. Requesters are served one per cycle, in round-robin order. Each granted request gets one registered response on the cycle after its grant. The response carries the requester index, a success flag and the slot contents from before the operation.

Top module: `vcas_unit`

## Requirements
- R1: After reset every slot holds pointer 0 and stamp 0. While reset is high, `rsp_valid` and every `req_ready` bit are 0.
- R2: A compare-and-swap (`req_op` bit = 0) whose expected pointer and expected stamp both equal the slot contents writes the new pointer, adds one to the stamp and returns `rsp_ok` = 1.
- R3: A compare-and-swap whose pointer matches but whose stamp differs returns `rsp_ok` = 0 and leaves the slot unchanged. This holds even after the pointer has gone away and come back to the same value.
- R4: A compare-and-swap whose pointer differs returns `rsp_ok` = 0 and leaves the slot unchanged.
- R5: Every response returns the pointer and stamp that the slot held just before the operation, whether it succeeded or failed.
- R6: The stamp wraps from all ones to zero on a successful write.
- R7: A test-and-set (`req_op` bit = 1) succeeds only when the slot pointer is 0. It then writes pointer 1 and adds one to the stamp. When the pointer is nonzero it fails and writes nothing. The expected and new fields are ignored.
- R8: At most one `req_ready` bit is high, and only for a valid requester. Whenever any requester is valid, one of them is granted. Each grant gives exactly one response on the next cycle with `rsp_id` equal to the granted index. No grant gives no response.
- R9: Grants rotate: after requester k is served, the next grant goes to the first valid requester after k, counting cyclically upward. After reset the search starts at requester 0.
- R10: Operations apply in grant order, one per cycle. An operation granted right after another on the same slot sees that slot's updated contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | N_REQ | Request present, one bit per requester |
| req_ready | output | N_REQ | Grant, one-hot; the request is taken at the clock edge |
| req_op | input | N_REQ | Operation per requester: 0 compare-and-swap, 1 test-and-set |
| req_addr | input | N_REQ*ADDR_W | Slot index, packed per requester |
| req_exp_ptr | input | N_REQ*PTR_W | Expected pointer, packed per requester |
| req_exp_stamp | input | N_REQ*STAMP_W | Expected stamp, packed per requester |
| req_new_ptr | input | N_REQ*PTR_W | Replacement pointer, packed per requester |
| rsp_valid | output | 1 | Response present |
| rsp_id | output | $clog2(N_REQ) | Index of the requester served |
| rsp_ok | output | 1 | Operation succeeded |
| rsp_ptr | output | PTR_W | Slot pointer before the operation |
| rsp_stamp | output | STAMP_W | Slot stamp before the operation |

## Verification
The bound checker checks the grant rules on every cycle: the grant is one-hot, it goes only to valid requesters, it never stalls when a request is waiting, and it does not repeat a requester while another is waiting. It also checks that a response follows each grant one cycle later, and only then. The data semantics can only be shown by the bench's scenarios, because they depend on slot history. These are the double-word compare, the rejection of a recycled pointer with an old stamp, the stamp wrap, test-and-set, and back-to-back contention on one slot. The bench compares each response against a model of the slots built from the requirements.

// File: rtl/vcas_pkg.sv
package vcas_pkg;
  typedef enum logic {
    OP_CAS = 1'b0,
    OP_TAS = 1'b1
  } vcas_op_e;
endpackage

// File: rtl/vcas_rr_arbiter.sv
module vcas_rr_arbiter #(
  parameter int N_REQ = 4,
  localparam int IDX_W = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_REQ-1:0] req,
  output logic [N_REQ-1:0] gnt,
  output logic [IDX_W-1:0] gnt_idx,
  output logic             any
);
  logic [IDX_W-1:0] last_q;

  always_comb begin
    int cand;
    gnt     = '0;
    gnt_idx = '0;
    any     = 1'b0;
    cand    = 0;
    for (int off = 1; off <= N_REQ; off++) begin
      cand = (int'(last_q) + off) % N_REQ;
      if (!any && req[cand]) begin
        any        = 1'b1;
        gnt[cand]  = 1'b1;
        gnt_idx    = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IDX_W'(N_REQ - 1);
    else if (any) last_q <= gnt_idx;
  end
endmodule

// File: rtl/vcas_slot_file.sv
module vcas_slot_file #(
  parameter int ADDR_W  = 3,
  parameter int PTR_W   = 32,
  parameter int STAMP_W = 32,
  localparam int DEPTH  = 2 ** ADDR_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  addr,
  output logic [PTR_W-1:0]   rd_ptr,
  output logic [STAMP_W-1:0] rd_stamp,
  input  logic               we,
  input  logic [PTR_W-1:0]   wr_ptr,
  input  logic [STAMP_W-1:0] wr_stamp
);
  logic [PTR_W-1:0]   ptr_q   [DEPTH];
  logic [STAMP_W-1:0] stamp_q [DEPTH];

  assign rd_ptr   = ptr_q[addr];
  assign rd_stamp = stamp_q[addr];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        ptr_q[i]   <= '0;
        stamp_q[i] <= '0;
      end
    end else if (we) begin
      ptr_q[addr]   <= wr_ptr;
      stamp_q[addr] <= wr_stamp;
    end
  end
endmodule

// File: rtl/vcas_alu.sv
module vcas_alu
  import vcas_pkg::*;
#(
  parameter int PTR_W   = 32,
  parameter int STAMP_W = 32
) (
  input  vcas_op_e           op,
  input  logic [PTR_W-1:0]   cur_ptr,
  input  logic [STAMP_W-1:0] cur_stamp,
  input  logic [PTR_W-1:0]   exp_ptr,
  input  logic [STAMP_W-1:0] exp_stamp,
  input  logic [PTR_W-1:0]   new_ptr,
  output logic               hit,
  output logic [PTR_W-1:0]   nxt_ptr,
  output logic [STAMP_W-1:0] nxt_stamp
);
  always_comb begin
    if (op == OP_TAS) begin
      hit     = (cur_ptr == '0);
      nxt_ptr = PTR_W'(1);
    end else begin
      hit     = (cur_ptr == exp_ptr) && (cur_stamp == exp_stamp);
      nxt_ptr = new_ptr;
    end
    nxt_stamp = cur_stamp + STAMP_W'(1);
  end
endmodule

// File: rtl/vcas_unit.sv
module vcas_unit
  import vcas_pkg::*;
#(
  parameter int N_REQ   = 4,
  parameter int ADDR_W  = 3,
  parameter int PTR_W   = 32,
  parameter int STAMP_W = 32,
  localparam int IDX_W  = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_REQ-1:0]           req_valid,
  output logic [N_REQ-1:0]           req_ready,
  input  logic [N_REQ-1:0]           req_op,
  input  logic [N_REQ*ADDR_W-1:0]    req_addr,
  input  logic [N_REQ*PTR_W-1:0]     req_exp_ptr,
  input  logic [N_REQ*STAMP_W-1:0]   req_exp_stamp,
  input  logic [N_REQ*PTR_W-1:0]     req_new_ptr,
  output logic                       rsp_valid,
  output logic [IDX_W-1:0]           rsp_id,
  output logic                       rsp_ok,
  output logic [PTR_W-1:0]           rsp_ptr,
  output logic [STAMP_W-1:0]         rsp_stamp
);
  logic [N_REQ-1:0]   gnt;
  logic [IDX_W-1:0]   sel;
  logic               take;
  logic [ADDR_W-1:0]  s_addr;
  logic [PTR_W-1:0]   s_exp_ptr, s_new_ptr, cur_ptr, nxt_ptr;
  logic [STAMP_W-1:0] s_exp_stamp, cur_stamp, nxt_stamp;
  vcas_op_e           s_op;
  logic               hit;

  vcas_rr_arbiter #(.N_REQ(N_REQ)) arb_i (
    .clk(clk), .rst(rst), .req(req_valid & {N_REQ{~rst}}),
    .gnt(gnt), .gnt_idx(sel), .any(take)
  );

  assign req_ready   = gnt;
  assign s_op        = vcas_op_e'(req_op[sel]);
  assign s_addr      = req_addr[int'(sel)*ADDR_W +: ADDR_W];
  assign s_exp_ptr   = req_exp_ptr[int'(sel)*PTR_W +: PTR_W];
  assign s_exp_stamp = req_exp_stamp[int'(sel)*STAMP_W +: STAMP_W];
  assign s_new_ptr   = req_new_ptr[int'(sel)*PTR_W +: PTR_W];

  vcas_slot_file #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .STAMP_W(STAMP_W)) slots_i (
    .clk(clk), .rst(rst), .addr(s_addr),
    .rd_ptr(cur_ptr), .rd_stamp(cur_stamp),
    .we(take && hit), .wr_ptr(nxt_ptr), .wr_stamp(nxt_stamp)
  );

  vcas_alu #(.PTR_W(PTR_W), .STAMP_W(STAMP_W)) alu_i (
    .op(s_op), .cur_ptr(cur_ptr), .cur_stamp(cur_stamp),
    .exp_ptr(s_exp_ptr), .exp_stamp(s_exp_stamp), .new_ptr(s_new_ptr),
    .hit(hit), .nxt_ptr(nxt_ptr), .nxt_stamp(nxt_stamp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_id    <= '0;
      rsp_ok    <= 1'b0;
      rsp_ptr   <= '0;
      rsp_stamp <= '0;
    end else begin
      rsp_valid <= take;
      if (take) begin
        rsp_id    <= sel;
        rsp_ok    <= hit;
        rsp_ptr   <= cur_ptr;
        rsp_stamp <= cur_stamp;
      end
    end
  end
endmodule

// File: rtl/vcas_unit_chk.sv
module vcas_unit_chk #(
  parameter int N_REQ = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [N_REQ-1:0] req_valid,
  input logic [N_REQ-1:0] req_ready,
  input logic             rsp_valid
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(req_ready)); // R8
  AST_GRANT_TO_VALID: assert property (@(posedge clk) disable iff (rst)
    (req_ready & ~req_valid) == '0); // R8
  AST_NO_IDLE_GRANT: assert property (@(posedge clk) disable iff (rst)
    (|req_valid) |-> (|req_ready)); // R8
  AST_RSP_AFTER_GRANT: assert property (@(posedge clk) disable iff (rst)
    (|req_ready) |=> rsp_valid); // R8
  AST_NO_RSP_WITHOUT_GRANT: assert property (@(posedge clk) disable iff (rst)
    !(|req_ready) |=> !rsp_valid); // R8
  AST_RR_NO_REPEAT: assert property (@(posedge clk) disable iff (rst)
    (|req_ready) |=> (((req_valid & ~$past(req_ready)) == '0) ||
                      ((req_ready & $past(req_ready)) == '0))); // R9
endmodule

bind vcas_unit vcas_unit_chk #(.N_REQ(N_REQ)) chk_i (
  .clk(clk), .rst(rst), .req_valid(req_valid),
  .req_ready(req_ready), .rsp_valid(rsp_valid)
);

// File: tb/vcas_unit_tb.sv
`timescale 1ns/1ps
module vcas_unit_tb_top;
  localparam int N  = 4;
  localparam int AW = 3;
  localparam int PW = 32;
  localparam int SW = 4;
  localparam int D  = 2 ** AW;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [N-1:0]    req_valid = '0;
  logic [N-1:0]    req_ready;
  logic [N-1:0]    req_op = '0;
  logic [N*AW-1:0] req_addr = '0;
  logic [N*PW-1:0] req_exp_ptr = '0;
  logic [N*SW-1:0] req_exp_stamp = '0;
  logic [N*PW-1:0] req_new_ptr = '0;
  logic            rsp_valid;
  logic [IW-1:0]   rsp_id;
  logic            rsp_ok;
  logic [PW-1:0]   rsp_ptr;
  logic [SW-1:0]   rsp_stamp;

  vcas_unit #(.N_REQ(N), .ADDR_W(AW), .PTR_W(PW), .STAMP_W(SW)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_exp_ptr(req_exp_ptr),
    .req_exp_stamp(req_exp_stamp), .req_new_ptr(req_new_ptr),
    .rsp_valid(rsp_valid), .rsp_id(rsp_id), .rsp_ok(rsp_ok),
    .rsp_ptr(rsp_ptr), .rsp_stamp(rsp_stamp)
  );

  typedef struct {
    int            id;
    logic          ok;
    logic [PW-1:0] ptr;
    logic [SW-1:0] stamp;
    string         tag;
  } item_t;

  item_t         sbq[$];
  int            total = 0;
  int            bad = 0;
  logic [PW-1:0] m_ptr[D];
  logic [SW-1:0] m_stamp[D];
  int            m_last = N - 1;

  function automatic item_t model_apply(int id, bit op, int addr, logic [PW-1:0] ep,
                                        logic [SW-1:0] es, logic [PW-1:0] np, string tag);
    item_t e;
    e.id = id; e.ptr = m_ptr[addr]; e.stamp = m_stamp[addr]; e.tag = tag;
    if (op) e.ok = (m_ptr[addr] == '0);
    else    e.ok = (m_ptr[addr] == ep) && (m_stamp[addr] == es);
    if (e.ok) begin
      m_ptr[addr]   = op ? PW'(1) : np;
      m_stamp[addr] = m_stamp[addr] + SW'(1);
    end
    m_last = id;
    return e;
  endfunction

  task automatic set_req(int i, bit op, int addr, logic [PW-1:0] ep,
                         logic [SW-1:0] es, logic [PW-1:0] np);
    req_valid[i] = 1'b1;
    req_op[i] = op;
    req_addr[i*AW +: AW] = AW'(addr);
    req_exp_ptr[i*PW +: PW] = ep;
    req_exp_stamp[i*SW +: SW] = es;
    req_new_ptr[i*PW +: PW] = np;
  endtask

  task automatic single(int i, bit op, int addr, logic [PW-1:0] ep,
                        logic [SW-1:0] es, logic [PW-1:0] np, string tag);
    @(negedge clk);
    set_req(i, op, addr, ep, es, np);
    #1;
    total++;
    if (req_ready !== N'(1 << i)) begin
      bad++;
      $display("FAIL R8 lone grant: actual=%b expected=%b", req_ready, N'(1 << i));
    end
    sbq.push_back(model_apply(i, op, addr, ep, es, np, tag));
    @(posedge clk);
    #1;
    req_valid[i] = 1'b0;
  endtask

  task automatic burst(bit op, int addr, logic [PW-1:0] ep, logic [SW-1:0] es,
                       logic [PW-1:0] np, string tag);
    logic [N-1:0] pend;
    @(negedge clk);
    for (int i = 0; i < N; i++) set_req(i, op, addr, ep, es, np + PW'(i));
    pend = '1;
    while (pend != '0) begin
      int p;
      p = 0;
      for (int off = N; off >= 1; off--)
        if (pend[(m_last + off) % N]) p = (m_last + off) % N;
      #1;
      total++;
      if (req_ready !== N'(1 << p)) begin
        bad++;
        $display("FAIL R9 rotation: actual=%b expected=%b", req_ready, N'(1 << p));
      end
      sbq.push_back(model_apply(p, op, addr, ep, es, np + PW'(p), tag));
      @(posedge clk);
      #1;
      req_valid[p] = 1'b0;
      pend[p] = 1'b0;
      @(negedge clk);
    end
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(negedge clk);
      if (!rst && rsp_valid) begin
        total++;
        if (sbq.size() == 0) begin
          bad++;
          $display("FAIL R8 response with none pending: actual id=%0d expected none", rsp_id);
        end else begin
          e = sbq.pop_front();
          if (rsp_id !== IW'(e.id) || rsp_ok !== e.ok ||
              rsp_ptr !== e.ptr || rsp_stamp !== e.stamp) begin
            bad++;
            $display("FAIL %s: actual id=%0d ok=%0d ptr=%h stamp=%h expected id=%0d ok=%0d ptr=%h stamp=%h",
                     e.tag, rsp_id, rsp_ok, rsp_ptr, rsp_stamp, e.id, e.ok, e.ptr, e.stamp);
          end
        end
      end
    end
  end

  initial begin : watchdog
    #(8 * 20000);
    bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    for (int a = 0; a < D; a++) begin m_ptr[a] = '0; m_stamp[a] = '0; end
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || req_ready !== '0) begin
      bad++;
      $display("FAIL R1 reset outputs: actual valid=%b ready=%b expected 0/0", rsp_valid, req_ready);
    end
    rst = 1'b0;
    // R1: untouched slot reads back zero through a failing swap
    single(0, 1'b0, 7, 32'h1, 4'h0, 32'h9, "R1");
    // R2/R5: matching pair succeeds; old contents returned
    single(1, 1'b0, 0, 32'h0, 4'h0, 32'hA, "R2");
    single(2, 1'b0, 0, 32'hA, 4'h0, 32'hB, "R3");
    single(3, 1'b0, 0, 32'h5, 4'h1, 32'hB, "R4");
    single(0, 1'b0, 0, 32'hA, 4'h1, 32'hC, "R5");
    // R3: pointer recycled A -> B -> A, stale stamp rejected
    single(3, 1'b0, 1, 32'h0, 4'h0, 32'hA0, "R2");
    single(2, 1'b0, 1, 32'hA0, 4'h1, 32'hB0, "R2");
    single(2, 1'b0, 1, 32'hB0, 4'h2, 32'hA0, "R2");
    single(0, 1'b0, 1, 32'hA0, 4'h1, 32'hC0, "R3");
    single(0, 1'b0, 1, 32'hA0, 4'h3, 32'hC0, "R3");
    // R7: test-and-set, expected fields ignored
    single(0, 1'b1, 2, 32'hFFFF, 4'hF, 32'h1234, "R7");
    single(1, 1'b1, 2, 32'h0, 4'h0, 32'h0, "R7");
    single(1, 1'b0, 2, 32'h1, 4'h1, 32'h0, "R7");
    single(3, 1'b1, 2, 32'h1, 4'h2, 32'h77, "R7");
    // R6: stamp wraps after sixteen successes
    for (int k = 0; k < 16; k++)
      single(1, 1'b0, 3, PW'(k), SW'(k), PW'(k + 1), "R6");
    single(1, 1'b0, 3, 32'd16, 4'h0, 32'd99, "R6");
    // R9/R10: contention on one slot, first served wins
    burst(1'b0, 4, 32'h0, 4'h0, 32'h40, "R10");
    single(0, 1'b0, 5, 32'h0, 4'h0, 32'h1, "R5");
    burst(1'b0, 4, 32'h42, 4'h1, 32'h50, "R10");
    burst(1'b1, 6, 32'h0, 4'h0, 32'h0, "R9");
    // R8: idle cycles produce no response
    repeat (6) @(negedge clk);
    total++;
    if (sbq.size() != 0) begin
      bad++;
      $display("FAIL R8 missing responses: actual pending=%0d expected 0", sbq.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule